// File: doc/BRIEF.md
# Command Parameter Collector and Busy Timer

This block is the execution front end of a geometry command engine. It pulls entries (an 8-bit command code plus a 32-bit parameter word) out of an upstream command pipe through a valid/pop handshake. Each parameter word goes into a 32-word buffer. A command is complete once it has collected as many words as its code needs. At that point the code's cycle cost is added to a signed busy counter, and the downstream datapath can read the collected words through a read port.

While the busy counter is positive, the block fetches nothing. Instead it counts time down using an advance input. That input reports CPU cycles elapsed; the engine runs at half that rate, so the count is halved and an odd leftover cycle is carried into the next advance. When the counter is at or below zero, the block drains one entry per clock. If the pipe has nothing to offer in that state, the counter is cleared to zero. The busy output is meant to appear directly in a status word.

Top module: `cmd_exec_front`

## Requirements
- R1: After reset, `busy` and `cmd_done` are 0, and `pipe_pop` stays 0 while `pipe_valid` is 0.
- R2: `pipe_pop` is asserted in a cycle only when `pipe_valid` is 1 and the busy counter is at or below zero. At most one entry is taken per clock. No entry is taken while `busy` is 1.
- R3: Each popped parameter word is written at the current buffer index, and the index then advances. After completion, word k of the command (counting from 0) is readable at `prm_rd_idx` = k.
- R4: A command completes on the pop that brings the collected count up to its parameter count. The count is 0 for codes 0x11, 0x15 and 0x41; 2 for 0x23 and 0x71; 3 for 0x1B, 0x1C and 0x70; 9 for 0x1A; 12 for 0x17 and 0x19; 16 for 0x16 and 0x18; 32 for 0x34; and 1 for every other defined code. A code with count 0 still takes one entry and completes on it. `cmd_done` pulses for one cycle after the completing pop, with `done_op` holding that code, and the index returns to 0.
- R5: On completion, the code's cost is added to the busy counter. Costs: 392 for 0x50; 103 for 0x70; 36 for 0x12 and 0x14; 35 for 0x18; 34 for 0x16; 32 for 0x34; 31 for 0x19; 30 for 0x17; 28 for 0x1A; 22 for 0x1B and 0x1C; 19 for 0x15; 17 for 0x11 and 0x13; 9 for 0x21, 0x23 and 0x71; 8 for 0x24 through 0x28; 6 for 0x32; 5 for 0x72; 4 for 0x30 and 0x31; 1 for 0x10, 0x20, 0x22, 0x29 through 0x2B, 0x33, 0x40, 0x41 and 0x60.
- R6: Each cycle with `adv_valid` high adds the held carry bit to `adv_cycles`, takes half of that sum as the advance amount and keeps the low bit as the new carry. If the counter is positive, it drops by that amount on the same edge. If the counter is at or below zero, it is not decremented.
- R7: When the counter is at or below zero and `pipe_valid` is 0, the counter becomes 0 on the next edge, so a negative balance is discarded.
- R8: `busy` is 1 exactly when the busy counter is greater than zero. A counter driven negative by an advance stays not-busy, and following costs are added to the negative value.
- R9: Any code not listed in R4 or R5 as defined needs no parameters and costs 0 cycles. It completes on one entry and leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_valid | input | 1 | Command pipe holds an entry |
| pipe_op | input | 8 | Command code of the head entry |
| pipe_prm | input | 32 | Parameter word of the head entry |
| pipe_pop | output | 1 | Head entry is taken at this edge |
| adv_valid | input | 1 | An advance step occurs this cycle |
| adv_cycles | input | 8 | CPU cycles elapsed for this step |
| busy | output | 1 | Busy counter above zero |
| cmd_done | output | 1 | One-cycle pulse after a command completes |
| done_op | output | 8 | Code of the last completed command |
| prm_rd_idx | input | 5 | Parameter buffer read index |
| prm_rd_data | output | 32 | Parameter word at the read index |

## Verification
A pop happens at the edge where `pipe_pop` is seen high. `cmd_done`, `done_op` and the `busy` that follows from the added cost are all due at the first edge after that pop. The bench therefore samples them at the falling edge right after the popping edge. An advance presented in one cycle takes effect in the counter at the next edge, so `busy` is checked half a clock later. The clearing of a negative balance takes a further idle edge. It is observed through the `busy` result of the command fed after that edge. `pipe_pop` is combinational from the registered counter and is checked 1 ns after the inputs change, before the edge that would act on it.

// File: rtl/cmd_exec_pkg.sv
package cmd_exec_pkg;
  localparam int OP_W      = 8;
  localparam int PRM_W     = 32;
  localparam int BUF_DEPTH = 32;
  localparam int NPRM_W    = $clog2(BUF_DEPTH) + 1;
  localparam int COST_W    = 9;
  localparam int CNT_W     = 16;
  localparam int ADV_W     = 8;
  localparam int COST_MAX  = 392;

  function automatic logic [COST_W-1:0] op_cost(input logic [OP_W-1:0] op);
    logic [COST_W-1:0] c;
    case (op)
      8'h50:                                     c = COST_W'(392);
      8'h70:                                     c = COST_W'(103);
      8'h12, 8'h14:                              c = COST_W'(36);
      8'h18:                                     c = COST_W'(35);
      8'h16:                                     c = COST_W'(34);
      8'h34:                                     c = COST_W'(32);
      8'h19:                                     c = COST_W'(31);
      8'h17:                                     c = COST_W'(30);
      8'h1A:                                     c = COST_W'(28);
      8'h1B, 8'h1C:                              c = COST_W'(22);
      8'h15:                                     c = COST_W'(19);
      8'h11, 8'h13:                              c = COST_W'(17);
      8'h21, 8'h23, 8'h71:                       c = COST_W'(9);
      8'h24, 8'h25, 8'h26, 8'h27, 8'h28:         c = COST_W'(8);
      8'h32:                                     c = COST_W'(6);
      8'h72:                                     c = COST_W'(5);
      8'h30, 8'h31:                              c = COST_W'(4);
      8'h10, 8'h20, 8'h22, 8'h29, 8'h2A, 8'h2B,
      8'h33, 8'h40, 8'h41, 8'h60:                c = COST_W'(1);
      default:                                   c = '0;
    endcase
    return c;
  endfunction

  function automatic logic [NPRM_W-1:0] op_nprm(input logic [OP_W-1:0] op);
    logic [NPRM_W-1:0] n;
    case (op)
      8'h34:                                     n = NPRM_W'(32);
      8'h16, 8'h18:                              n = NPRM_W'(16);
      8'h17, 8'h19:                              n = NPRM_W'(12);
      8'h1A:                                     n = NPRM_W'(9);
      8'h1B, 8'h1C, 8'h70:                       n = NPRM_W'(3);
      8'h23, 8'h71:                              n = NPRM_W'(2);
      8'h10, 8'h12, 8'h13, 8'h14, 8'h20, 8'h21,
      8'h22, 8'h24, 8'h25, 8'h26, 8'h27, 8'h28,
      8'h29, 8'h2A, 8'h2B, 8'h30, 8'h31, 8'h32,
      8'h33, 8'h40, 8'h50, 8'h60, 8'h72:         n = NPRM_W'(1);
      default:                                   n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/cef_tables.sv
module cef_tables
  import cmd_exec_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int CW  = COST_W,
  parameter int NW  = NPRM_W
) (
  input  logic [OPW-1:0] op,
  output logic [CW-1:0]  cost,
  output logic [NW-1:0]  nprm
);
  always_comb begin
    cost = CW'(op_cost(OP_W'(op)));
    nprm = NW'(op_nprm(OP_W'(op)));
  end
endmodule

// File: rtl/cef_halver.sv
module cef_halver #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_valid,
  input  logic [AW-1:0] adv_cycles,
  output logic [AW-1:0] half
);
  logic          carry_q, carry_d;
  logic [AW:0]   total;

  always_comb begin
    total   = {1'b0, adv_cycles} + {{AW{1'b0}}, carry_q};
    half    = total[AW:1];
    carry_d = adv_valid ? total[0] : carry_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  // R6: the carry bit only moves on an advance step
  a_r6_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_valid |=> $stable(carry_q));
endmodule

// File: rtl/cef_collector.sv
module cef_collector #(
  parameter int OPW   = 8,
  parameter int PW    = 32,
  parameter int DEPTH = 32,
  parameter int NW    = 6,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pop,
  input  logic [OPW-1:0] op,
  input  logic [PW-1:0]  prm,
  input  logic [NW-1:0]  nprm,
  input  logic [IW-1:0]  rd_idx,
  output logic [PW-1:0]  rd_data,
  output logic           complete,
  output logic           done_q,
  output logic [OPW-1:0] done_op_q
);
  logic [IW-1:0]  idx_q, idx_d;
  logic [NW-1:0]  gathered;
  logic [PW-1:0]  buf_q [DEPTH];
  logic           done_d;
  logic [OPW-1:0] done_op_d;

  always_comb begin
    gathered  = NW'(idx_q) + NW'(1);
    complete  = pop && (gathered >= nprm);
    idx_d     = idx_q;
    if (pop) idx_d = complete ? '0 : idx_q + IW'(1);
    done_d    = complete;
    done_op_d = complete ? op : done_op_q;
    rd_data   = buf_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      done_q    <= 1'b0;
      done_op_q <= '0;
    end else begin
      idx_q     <= idx_d;
      done_q    <= done_d;
      done_op_q <= done_op_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           buf_q[g] <= '0;
      else if (pop && idx_q == IW'(g))      buf_q[g] <= prm;
    end
  end

  // R4: after a completion the collection index has returned to zero
  a_r4_idx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> idx_q == '0);
  // R3: a non-completing pop advances the index by one
  a_r3_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !complete) |=> idx_q == $past(idx_q) + IW'(1));
endmodule

// File: rtl/cef_timer.sv
module cef_timer #(
  parameter int CW   = 9,
  parameter int AW   = 8,
  parameter int NB   = 16,
  parameter int CMAX = 392
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pipe_valid,
  input  logic          complete,
  input  logic [CW-1:0] cost,
  input  logic          adv_valid,
  input  logic [AW-1:0] half,
  output logic          busy,
  output logic          idle
);
  logic signed [NB-1:0] cnt_q, cnt_d;
  logic signed [NB-1:0] cost_s, half_s;

  always_comb begin
    cost_s = $signed(NB'(cost));
    half_s = $signed(NB'(half));
    busy   = cnt_q > 0;
    idle   = !busy;
    cnt_d  = cnt_q;
    if (busy) begin
      if (adv_valid) cnt_d = cnt_q - half_s;
    end else if (pipe_valid) begin
      if (complete) cnt_d = cnt_q + cost_s;
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R7: an idle counter with nothing to fetch is cleared
  a_r7_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= 0 && !pipe_valid) |=> cnt_q == 0);
  // R5: the balance never exceeds the largest single cost
  a_r5_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= $signed(NB'(CMAX)));
  // R6: a busy advance lowers the counter by the halved amount
  a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adv_valid) |=> cnt_q == $past(cnt_q) - $past(half_s));
endmodule

// File: rtl/cmd_exec_front.sv
module cmd_exec_front
  import cmd_exec_pkg::*;
#(
  parameter int OPW   = OP_W,
  parameter int PW    = PRM_W,
  parameter int DEPTH = BUF_DEPTH,
  parameter int AW    = ADV_W,
  parameter int NB    = CNT_W,
  localparam int IW   = $clog2(DEPTH),
  localparam int NW   = IW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pipe_valid,
  input  logic [OPW-1:0] pipe_op,
  input  logic [PW-1:0]  pipe_prm,
  output logic           pipe_pop,
  input  logic           adv_valid,
  input  logic [AW-1:0]  adv_cycles,
  output logic           busy,
  output logic           cmd_done,
  output logic [OPW-1:0] done_op,
  input  logic [IW-1:0]  prm_rd_idx,
  output logic [PW-1:0]  prm_rd_data
);
  logic [COST_W-1:0] cost;
  logic [NW-1:0]     nprm;
  logic [AW-1:0]     half;
  logic              idle, complete;

  assign pipe_pop = idle && pipe_valid;

  cef_tables #(.OPW(OPW), .CW(COST_W), .NW(NW)) u_tables (
    .op(pipe_op), .cost(cost), .nprm(nprm));

  cef_halver #(.AW(AW)) u_halver (
    .clk(clk), .rst_n(rst_n), .adv_valid(adv_valid),
    .adv_cycles(adv_cycles), .half(half));

  cef_collector #(.OPW(OPW), .PW(PW), .DEPTH(DEPTH), .NW(NW)) u_collect (
    .clk(clk), .rst_n(rst_n), .pop(pipe_pop), .op(pipe_op), .prm(pipe_prm),
    .nprm(nprm), .rd_idx(prm_rd_idx), .rd_data(prm_rd_data),
    .complete(complete), .done_q(cmd_done), .done_op_q(done_op));

  cef_timer #(.CW(COST_W), .AW(AW), .NB(NB), .CMAX(COST_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n), .pipe_valid(pipe_valid), .complete(complete),
    .cost(cost), .adv_valid(adv_valid), .half(half), .busy(busy), .idle(idle));

  // R2: nothing leaves the pipe while the engine is busy
  a_r2_no_pop_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pipe_pop);
endmodule

// File: tb/cmd_exec_front_tb_top.sv
module cmd_exec_front_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_valid = 1'b0;
  logic [7:0]  pipe_op = '0;
  logic [31:0] pipe_prm = '0;
  logic        pipe_pop;
  logic        adv_valid = 1'b0;
  logic [7:0]  adv_cycles = '0;
  logic        busy, cmd_done;
  logic [7:0]  done_op;
  logic [4:0]  prm_rd_idx = '0;
  logic [31:0] prm_rd_data;

  int checks = 0;
  int fails  = 0;
  int mcarry = 0;

  always #5 clk = ~clk;

  cmd_exec_front dut_i (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int half_of(input int n);
    int t = n + mcarry;
    mcarry = t % 2;
    return t / 2;
  endfunction

  // Present one entry and wait for it to be taken; returns at the following negedge.
  task automatic send(input logic [7:0] op, input logic [31:0] prm);
    @(negedge clk);
    pipe_valid = 1'b1; pipe_op = op; pipe_prm = prm;
    #1;
    while (!pipe_pop) begin @(negedge clk); #1; end
    @(negedge clk);
    pipe_valid = 1'b0;
  endtask

  task automatic advance(input int n);
    @(negedge clk);
    adv_valid = 1'b1; adv_cycles = 8'(n);
    @(negedge clk);
    adv_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy == 0, "R1 busy", busy, 0);
    check(cmd_done == 0, "R1 done", cmd_done, 0);
    check(pipe_pop == 0, "R1 pop", pipe_pop, 0);
  endtask

  task automatic t_zero_param_and_advance;
    int exp = 17;
    send(8'h11, 32'h0);
    check(cmd_done == 1, "R4 zero-param done", cmd_done, 1);
    check(done_op == 8'h11, "R4 done code", done_op, 8'h11);
    check(busy == 1, "R5 cost 17 busy", busy, 1);
    pipe_valid = 1'b1; pipe_op = 8'h20;
    for (int i = 0; i < 3; i++) begin
      #1; check(pipe_pop == 0, "R2 gated while busy", pipe_pop, 0);
      @(negedge clk);
    end
    check(cmd_done == 0, "R4 single pulse", cmd_done, 0);
    pipe_valid = 1'b0;
    exp -= half_of(10); advance(10);
    check(busy == (exp > 0), "R6 adv 10", busy, exp > 0);
    exp -= half_of(7);  advance(7);
    check(busy == (exp > 0), "R6 adv 7 odd", busy, exp > 0);
    exp -= half_of(1);  advance(1);
    check(busy == (exp > 0), "R6 carry", busy, exp > 0);
    exp -= half_of(15); advance(15);
    check(busy == 1 && exp == 1, "R6 one left", busy, 1);
    exp -= half_of(1);  advance(1);
    check(busy == 0 && exp == 0, "R8 reaches zero", busy, 0);
  endtask

  task automatic t_multi_param;
    send(8'h1B, 32'hA0A0_0001);
    check(cmd_done == 0, "R4 1 of 3", cmd_done, 0);
    send(8'h1B, 32'hB0B0_0002);
    check(cmd_done == 0, "R4 2 of 3", cmd_done, 0);
    check(busy == 0, "R5 no cost early", busy, 0);
    send(8'h1B, 32'hC0C0_0003);
    check(cmd_done == 1 && done_op == 8'h1B, "R4 3 of 3", done_op, 8'h1B);
    check(busy == 1, "R5 cost 22", busy, 1);
    prm_rd_idx = 5'd0; #1;
    check(prm_rd_data == 32'hA0A0_0001, "R3 word 0", prm_rd_data, 32'hA0A0_0001);
    prm_rd_idx = 5'd1; #1;
    check(prm_rd_data == 32'hB0B0_0002, "R3 word 1", prm_rd_data, 32'hB0B0_0002);
    prm_rd_idx = 5'd2; #1;
    check(prm_rd_data == 32'hC0C0_0003, "R3 word 2", prm_rd_data, 32'hC0C0_0003);
    begin
      int h = half_of(44);
      advance(44);
      check(busy == (22 - h > 0), "R6 clear 22", busy, 22 - h > 0);
    end
  endtask

  task automatic t_undefined;
    send(8'h00, 32'h5);
    check(cmd_done == 1 && done_op == 8'h00, "R9 code 00 done", done_op, 0);
    check(busy == 0, "R9 code 00 cost", busy, 0);
    send(8'hFF, 32'h6);
    check(cmd_done == 1 && done_op == 8'hFF, "R9 code FF done", done_op, 8'hFF);
    check(busy == 0, "R9 code FF cost", busy, 0);
  endtask

  task automatic t_negative_and_clear;
    int h;
    send(8'h10, 32'h1);
    check(busy == 1, "R5 cost 1", busy, 1);
    @(negedge clk);
    h = half_of(10);
    pipe_valid = 1'b1; pipe_op = 8'h20; adv_valid = 1'b1; adv_cycles = 8'd10;
    #1; check(pipe_pop == 0, "R2 busy during advance", pipe_pop, 0);
    @(negedge clk);
    adv_valid = 1'b0;
    check(busy == 0, "R8 negative not busy", busy, 0);
    #1; check(pipe_pop == 1, "R2 fetch when idle", pipe_pop, 1);
    @(negedge clk);
    check(busy == 0 && cmd_done == 1, "R8 cost added to negative", busy, 0);
    pipe_op = 8'h33;
    #1; check(pipe_pop == 1, "R2 back to back", pipe_pop, 1);
    @(negedge clk);
    check(busy == (1 - h + 2 > 0), "R8 still negative", busy, 0);
    pipe_valid = 1'b0;
    @(negedge clk);
    send(8'h20, 32'h2);
    check(busy == 1, "R7 negative balance dropped", busy, 1);
    h = half_of(2); advance(2);
    check(busy == (1 - h > 0), "R6 clear", busy, 0);
  endtask

  task automatic t_long_costs;
    int exp;
    send(8'h70, 32'h1); send(8'h70, 32'h2);
    check(cmd_done == 0, "R4 box 2 of 3", cmd_done, 0);
    send(8'h70, 32'h3);
    check(cmd_done == 1 && busy == 1, "R5 cost 103", busy, 1);
    exp = 103;
    exp -= half_of(200); advance(200);
    check(busy == (exp > 0), "R6 adv 200", busy, exp > 0);
    while (exp > 0) begin
      int n = 2 * exp;
      exp -= half_of(n); advance(n);
    end
    check(busy == 0, "R6 box drained", busy, 0);
    send(8'h50, 32'h0);
    check(busy == 1 && done_op == 8'h50, "R5 cost 392", busy, 1);
    exp = 392;
    for (int i = 0; i < 3; i++) begin
      exp -= half_of(255); advance(255);
      check(busy == (exp > 0), "R6 big steps", busy, exp > 0);
    end
    while (exp > 0) begin
      int n = (2 * exp > 255) ? 255 : 2 * exp;
      exp -= half_of(n); advance(n);
    end
    check(busy == 0, "R8 swap drained", busy, 0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_zero_param_and_advance();
    t_multi_param();
    t_undefined();
    t_negative_and_clear();
    t_long_costs();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule